// File: doc/BRIEF.md
# PCMCIA I/O Cycle Dynamic Sizer

This block turns single processor-side I/O requests into read or write strobe cycles on a 16-bit PCMCIA I/O card bus. A request gives an address within a 64 MB I/O window, a card select (one of two), a byte or word size, a direction and write data. The block starts a request with a one-clock start strobe while it is idle. It then drives the card address, the write data and a read or write strobe. When the request is finished it returns read data with a one-clock done pulse.

The card reports the width of its port on the IOIS16 input, where high means an 8-bit port. When the block runs in little-endian mode on a 16-bit card bus, it reads that input during the first strobe cycle of a request. If a word access meets an 8-bit port, the block moves only the low byte in that cycle. It then runs a second byte cycle on its own at the next address and carries the upper byte on the low data lines. A byte access at an odd address is routed to the high lanes or the low lanes by the same decision. Each card select has its own programmed wait count. The card can hold its wait input active to lengthen any strobe.

Top module: `pcm_io_sizer`

## Requirements
- R1: While reset is held and after it is released, both strobes and both card selects are low, the done output is low and the read result is zero.
- R2: A word access to a 16-bit port (IOIS16 low) is a single strobe cycle at the request address. A write drives all 16 bits as given. A read returns the whole bus, with data lines 15:8 as the upper byte.
- R3: With sizing enabled, a word access that sees IOIS16 high becomes two strobe cycles. The first is at the request address and moves the low byte. The second is at that address plus one and moves the upper byte on lines 7:0. A read returns the first byte in bits 7:0 and the second byte in bits 15:8.
- R4: Sizing is enabled only while little-endian mode and 16-bit bus width are both set. Otherwise every request is one strobe cycle, whatever the level of IOIS16.
- R5: A byte read returns its byte in bits 7:0 and zero in bits 15:8. The address keeps bit 0 as requested. An odd-address byte comes from lines 15:8 when IOIS16 is low on a 16-bit bus. It comes from lines 7:0 when IOIS16 is high or the bus is 8 bits. An even-address byte always comes from lines 7:0.
- R6: A byte write drives the byte on both data lanes, lines 15:8 and lines 7:0.
- R7: Each strobe stays high for the wait count of the selected card plus one clock. Card-select output bit 0 serves select 0 and bit 1 serves select 1. Exactly the selected bit is high while a strobe is high.
- R8: Each clock in which the card wait input is high, once the programmed count has run out, keeps the strobe high one clock longer.
- R9: A start strobe that arrives while a request is in progress is ignored. It causes no extra cycle and does not change the address of the current request.
- R10: The read and write strobes are never high together. The two cycles of a split word are separated by at least one clock with no strobe.
- R11: Done is a single-clock pulse in the clock that follows the end of the last strobe of a request. A split word gives one pulse only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_little | input | 1 | Little-endian mode enable |
| cfg_bus16 | input | 1 | Card bus is 16 bits wide |
| cfg_wait0 | input | WAIT_W | Wait count for card select 0 |
| cfg_wait1 | input | WAIT_W | Wait count for card select 1 |
| req_start | input | 1 | Start strobe, accepted only when idle |
| req_addr | input | ADDR_W | I/O address of the request |
| req_sel | input | 1 | Card select (0 or 1) |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_done | output | 1 | Request complete pulse |
| rsp_rdata | output | 16 | Read result, valid with and after done |
| card_addr | output | ADDR_W | Card address |
| card_ce | output | 2 | Card select outputs, one per card |
| card_rd | output | 1 | Read strobe, active high |
| card_wr | output | 1 | Write strobe, active high |
| card_wdata | output | 16 | Card write data |
| card_rdata | input | 16 | Card read data |
| card_wait | input | 1 | Card wait request, active high |
| card_iois16 | input | 1 | High when the card port is 8 bits wide |

## Verification
The properties assume three things about the inputs. Word requests use even addresses. The configuration inputs do not change while a request is in progress. The card's wait and port-width inputs are valid at each clock edge. The bench holds the configuration fixed across each request and uses only even addresses for word requests. It drives IOIS16 and the wait input from the falling edge and holds IOIS16 constant for the whole request, so the properties on strobe exclusivity, select onehotness, address stability and the done pulse are checked under conditions they are meant for.

// File: rtl/pcm_io_pkg.sv
package pcm_io_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NUM_CS = 2;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2
    } sq_state_t;

    typedef enum logic [1:0] {
        RM_WORD  = 2'd0,
        RM_LOW   = 2'd1,
        RM_HIGH  = 2'd2,
        RM_UPPER = 2'd3
    } rd_mode_t;

    typedef struct packed {
        logic sel;
        logic word;
        logic write;
    } req_ctl_t;

    function automatic logic [BUS_W-1:0] dup_byte(input logic [BYTE_W-1:0] b);
        return {b, b};
    endfunction

    function automatic logic [NUM_CS-1:0] cs_decode(input logic sel);
        logic [NUM_CS-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pcm_wait_timer.sv
module pcm_wait_timer #(
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    input  logic              card_wait,
    output logic              expire
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - WAIT_W'(1);
        end
    end

    assign expire = run && (cnt_q == '0) && !card_wait;

endmodule

// File: rtl/pcm_read_pack.sv
module pcm_read_pack
    import pcm_io_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap,
    input  rd_mode_t         mode,
    input  logic [BUS_W-1:0] bus,
    output logic [BUS_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rdata <= '0;
        end else if (cap) begin
            case (mode)
                RM_WORD:  rdata <= bus;
                RM_LOW:   rdata <= {{BYTE_W{1'b0}}, bus[BYTE_W-1:0]};
                RM_HIGH:  rdata <= {{BYTE_W{1'b0}}, bus[BUS_W-1:BYTE_W]};
                default:  rdata[BUS_W-1:BYTE_W] <= bus[BYTE_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/pcm_io_sizer.sv
module pcm_io_sizer
    import pcm_io_pkg::*;
#(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_little,
    input  logic              cfg_bus16,
    input  logic [WAIT_W-1:0] cfg_wait0,
    input  logic [WAIT_W-1:0] cfg_wait1,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_sel,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] card_addr,
    output logic [1:0]        card_ce,
    output logic              card_rd,
    output logic              card_wr,
    output logic [15:0]       card_wdata,
    input  logic [15:0]       card_rdata,
    input  logic              card_wait,
    input  logic              card_iois16
);
    sq_state_t         state_q;
    req_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    logic              phase_q;
    logic              narrow_q;
    logic              first_q;
    logic              done_q;

    logic              accept;
    logic              strobe;
    logic              dyn_en;
    logic              narrow_now;
    logic              split_now;
    logic              end_cycle;
    logic              timer_load;
    logic              wait_sel;
    logic [WAIT_W-1:0] wait_val;
    logic              expire;
    rd_mode_t          rd_mode;

    assign dyn_en     = cfg_little & cfg_bus16;
    assign accept     = (state_q == SQ_IDLE) && req_start;
    assign strobe     = (state_q == SQ_STROBE);
    assign narrow_now = first_q ? card_iois16 : narrow_q;
    assign split_now  = dyn_en && ctl_q.word && narrow_now && !phase_q;
    assign end_cycle  = strobe && expire;
    assign timer_load = accept || (state_q == SQ_GAP);
    assign wait_sel   = accept ? req_sel : ctl_q.sel;
    assign wait_val   = wait_sel ? cfg_wait1 : cfg_wait0;

    pcm_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (timer_load),
        .load_val  (wait_val),
        .run       (strobe),
        .card_wait (card_wait),
        .expire    (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            ctl_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            phase_q  <= 1'b0;
            narrow_q <= 1'b0;
            first_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        ctl_q    <= '{sel: req_sel, word: req_word, write: req_write};
                        addr_q   <= req_addr;
                        wdata_q  <= req_wdata;
                        phase_q  <= 1'b0;
                        first_q  <= 1'b1;
                        state_q  <= SQ_STROBE;
                    end
                end
                SQ_STROBE: begin
                    first_q  <= 1'b0;
                    narrow_q <= narrow_now;
                    if (end_cycle) begin
                        if (split_now) begin
                            phase_q <= 1'b1;
                            state_q <= SQ_GAP;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                SQ_GAP: begin
                    first_q <= 1'b1;
                    state_q <= SQ_STROBE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        if (phase_q) begin
            rd_mode = RM_UPPER;
        end else if (ctl_q.word) begin
            rd_mode = (dyn_en && narrow_now) ? RM_LOW : RM_WORD;
        end else if (addr_q[0] && cfg_bus16 && !(dyn_en && narrow_now)) begin
            rd_mode = RM_HIGH;
        end else begin
            rd_mode = RM_LOW;
        end
    end

    pcm_read_pack u_pack (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .cap   (end_cycle && !ctl_q.write),
        .mode  (rd_mode),
        .bus   (card_rdata),
        .rdata (rsp_rdata)
    );

    always_comb begin
        if (phase_q) begin
            card_wdata = dup_byte(wdata_q[BUS_W-1:BYTE_W]);
        end else if (ctl_q.word) begin
            card_wdata = wdata_q;
        end else begin
            card_wdata = dup_byte(wdata_q[BYTE_W-1:0]);
        end
    end

    assign card_addr = phase_q ? (addr_q + ADDR_W'(1)) : addr_q;
    assign card_rd   = strobe && !ctl_q.write;
    assign card_wr   = strobe && ctl_q.write;
    assign card_ce   = strobe ? cs_decode(ctl_q.sel) : '0;
    assign rsp_done  = done_q;

endmodule

// File: rtl/pcm_io_sizer_chk.sv
module pcm_io_sizer_chk #(
    parameter int unsigned ADDR_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              card_rd,
    input logic              card_wr,
    input logic [1:0]        card_ce,
    input logic [ADDR_W-1:0] card_addr,
    input logic              rsp_done
);
    logic stb;
    assign stb = card_rd | card_wr;

    a_r10_excl_strobes: assert property (@(posedge clk) disable iff (rst)
        !(card_rd && card_wr));

    a_r7_one_select: assert property (@(posedge clk) disable iff (rst)
        stb |-> ($countones(card_ce) == 1));

    a_r7_no_select_idle: assert property (@(posedge clk) disable iff (rst)
        !stb |-> (card_ce == 2'b00));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (stb && $past(stb)) |-> $stable(card_addr));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r11_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_done) |-> ($past(stb) && !stb));

endmodule

bind pcm_io_sizer pcm_io_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .card_rd   (card_rd),
    .card_wr   (card_wr),
    .card_ce   (card_ce),
    .card_addr (card_addr),
    .rsp_done  (rsp_done)
);

// File: tb/tb_pcm_io_sizer.sv
module tb_pcm_io_sizer;
    localparam int ADDR_W = 26;
    localparam int WAIT_W = 4;
    localparam logic [WAIT_W-1:0] W0 = 4'd2;
    localparam logic [WAIT_W-1:0] W1 = 4'd5;

    typedef struct packed {
        logic              sel;
        logic              word;
        logic              wr;
        logic              iois;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wd;
        logic [15:0]       rd;
        logic [1:0]        cyc;
        logic [15:0]       fwd;
        logic [15:0]       lwd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 26'h124, 16'h0000, 16'hDB24, 2'd1, 16'h0000, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 1'b1, 26'h2A0, 16'h0000, 16'hA1A0, 2'd2, 16'h0000, 16'h0000},
        '{1'b0, 1'b0, 1'b0, 1'b0, 26'h357, 16'h0000, 16'h00A8, 2'd1, 16'h0000, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 26'h357, 16'h0000, 16'h0057, 2'd1, 16'h0000, 16'h0000},
        '{1'b0, 1'b0, 1'b0, 1'b1, 26'h356, 16'h0000, 16'h0056, 2'd1, 16'h0000, 16'h0000},
        '{1'b0, 1'b1, 1'b1, 1'b0, 26'h100, 16'hBEEF, 16'h0000, 2'd1, 16'hBEEF, 16'hBEEF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 26'h200, 16'h1234, 16'h0000, 2'd2, 16'h1234, 16'h1212},
        '{1'b0, 1'b0, 1'b1, 1'b1, 26'h0FF, 16'h00C3, 16'h0000, 2'd1, 16'hC3C3, 16'hC3C3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_little = 1'b1;
    logic              cfg_bus16 = 1'b1;
    logic [WAIT_W-1:0] cfg_wait0 = W0;
    logic [WAIT_W-1:0] cfg_wait1 = W1;
    logic              req_start = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_sel = 1'b0;
    logic              req_word = 1'b0;
    logic              req_write = 1'b0;
    logic [15:0]       req_wdata = '0;
    logic              rsp_done;
    logic [15:0]       rsp_rdata;
    logic [ADDR_W-1:0] card_addr;
    logic [1:0]        card_ce;
    logic              card_rd;
    logic              card_wr;
    logic [15:0]       card_wdata;
    logic [15:0]       card_rdata;
    logic              card_wait = 1'b0;
    logic              card_iois16 = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    assign card_rdata = {~card_addr[7:0], card_addr[7:0]};

    pcm_io_sizer #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst(rst), .cfg_little(cfg_little), .cfg_bus16(cfg_bus16),
        .cfg_wait0(cfg_wait0), .cfg_wait1(cfg_wait1), .req_start(req_start),
        .req_addr(req_addr), .req_sel(req_sel), .req_word(req_word),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .card_addr(card_addr), .card_ce(card_ce),
        .card_rd(card_rd), .card_wr(card_wr), .card_wdata(card_wdata),
        .card_rdata(card_rdata), .card_wait(card_wait), .card_iois16(card_iois16)
    );

    // bus monitor: cumulative counts, never reset by the stimulus
    int                tot_clks = 0;
    int                tot_cyc  = 0;
    int                tot_done = 0;
    logic              stb_prev = 1'b0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [15:0]       last_wd = '0;
    logic [15:0]       pre_wd = '0;
    logic [1:0]        last_ce = '0;

    always @(posedge clk) begin
        if (!rst) begin
            if (card_rd || card_wr) begin
                tot_clks = tot_clks + 1;
                if (!stb_prev) begin
                    tot_cyc   = tot_cyc + 1;
                    pre_wd    = last_wd;
                    last_wd   = card_wdata;
                    last_addr = card_addr;
                    last_ce   = card_ce;
                end
            end
            if (rsp_done) tot_done = tot_done + 1;
        end
        stb_prev = card_rd || card_wr;
    end

    int snap_clks, snap_cyc, snap_done;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_req(input logic sel, input logic word, input logic wr,
                             input logic [ADDR_W-1:0] addr, input logic [15:0] wd,
                             input logic iois);
        @(negedge clk);
        snap_clks = tot_clks;
        snap_cyc  = tot_cyc;
        snap_done = tot_done;
        req_sel = sel; req_word = word; req_write = wr;
        req_addr = addr; req_wdata = wd; card_iois16 = iois;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] rd);
        bit seen;
        seen = 1'b0;
        rd = '0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (rsp_done) begin
                seen = 1'b1;
                rd = rsp_rdata;
            end
        end
        check(seen, "R11", "done seen", longint'(seen), 1);
        @(negedge clk);
        check(!rsp_done, "R11", "done one clock", longint'(rsp_done), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int w;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check(!card_rd && !card_wr && card_ce == 0 && !rsp_done, "R1", "held reset outputs",
              {card_rd, card_wr, card_ce, rsp_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!card_rd && !card_wr && card_ce == 0 && !rsp_done, "R1", "idle outputs",
              {card_rd, card_wr, card_ce, rsp_done}, 0);
        check(rsp_rdata == 16'h0, "R1", "rdata after reset", rsp_rdata, 0);

        // table of vectors: R2 R3 R5 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            drive_req(VECS[v].sel, VECS[v].word, VECS[v].wr, VECS[v].addr, VECS[v].wd, VECS[v].iois);
            wait_done(rd);
            w = VECS[v].sel ? int'(W1) : int'(W0);
            check(tot_cyc - snap_cyc == int'(VECS[v].cyc), "R3", "cycle count",
                  tot_cyc - snap_cyc, VECS[v].cyc);
            check(tot_clks - snap_clks == int'(VECS[v].cyc) * (w + 1), "R7", "strobe clocks",
                  tot_clks - snap_clks, int'(VECS[v].cyc) * (w + 1));
            check(last_ce == (VECS[v].sel ? 2'b10 : 2'b01), "R7", "card select",
                  last_ce, VECS[v].sel ? 2'b10 : 2'b01);
            check(tot_done - snap_done == 1, "R11", "done count", tot_done - snap_done, 1);
            check(last_addr == ((VECS[v].cyc == 2'd2) ? VECS[v].addr + 26'd1 : VECS[v].addr),
                  "R5", "last address", last_addr,
                  (VECS[v].cyc == 2'd2) ? VECS[v].addr + 26'd1 : VECS[v].addr);
            if (VECS[v].wr) begin
                check(last_wd == VECS[v].lwd, "R6", "last write data", last_wd, VECS[v].lwd);
                check(((VECS[v].cyc == 2'd2) ? pre_wd : last_wd) == VECS[v].fwd, "R2",
                      "first write data", (VECS[v].cyc == 2'd2) ? pre_wd : last_wd, VECS[v].fwd);
            end else begin
                check(rd == VECS[v].rd, "R5", "read result", rd, VECS[v].rd);
            end
        end

        // R4: sizing off without little-endian mode
        cfg_little = 1'b0;
        drive_req(1'b0, 1'b1, 1'b0, 26'h2A0, 16'h0, 1'b1);
        wait_done(rd);
        check(tot_cyc - snap_cyc == 1, "R4", "big-endian cycles", tot_cyc - snap_cyc, 1);
        check(rd == 16'h5FA0, "R4", "big-endian word", rd, 16'h5FA0);
        cfg_little = 1'b1;

        // R4: sizing off on an 8-bit bus
        cfg_bus16 = 1'b0;
        drive_req(1'b0, 1'b1, 1'b0, 26'h2A0, 16'h0, 1'b1);
        wait_done(rd);
        check(tot_cyc - snap_cyc == 1, "R4", "8-bit bus cycles", tot_cyc - snap_cyc, 1);
        check(rd == 16'h5FA0, "R4", "8-bit bus word", rd, 16'h5FA0);
        drive_req(1'b0, 1'b0, 1'b0, 26'h357, 16'h0, 1'b0);
        wait_done(rd);
        check(rd == 16'h0057, "R5", "odd byte on 8-bit bus", rd, 16'h0057);
        cfg_bus16 = 1'b1;

        // R8: card wait stretches the strobe
        card_wait = 1'b1;
        drive_req(1'b0, 1'b1, 1'b0, 26'h124, 16'h0, 1'b0);
        repeat (6) @(negedge clk);
        card_wait = 1'b0;
        wait_done(rd);
        check(tot_clks - snap_clks == 7, "R8", "stretched strobe clocks", tot_clks - snap_clks, 7);
        check(rd == 16'hDB24, "R8", "read after wait", rd, 16'hDB24);

        // R9: start while busy is ignored
        drive_req(1'b0, 1'b1, 1'b0, 26'h124, 16'h0, 1'b0);
        @(negedge clk);
        req_addr = 26'h300;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done(rd);
        repeat (10) @(negedge clk);
        check(tot_cyc - snap_cyc == 1, "R9", "cycles with busy start", tot_cyc - snap_cyc, 1);
        check(last_addr == 26'h124, "R9", "address kept", last_addr, 26'h124);
        check(tot_done - snap_done == 1, "R9", "single done", tot_done - snap_done, 1);
        check(rd == 16'hDB24, "R9", "read unaffected", rd, 16'hDB24);

        // R10: split cycles never overlap strobes
        drive_req(1'b0, 1'b1, 1'b0, 26'h2A0, 16'h0, 1'b1);
        wait_done(rd);
        check(tot_cyc - snap_cyc == 2, "R10", "two separated cycles", tot_cyc - snap_cyc, 2);
        check(rd == 16'hA1A0, "R3", "split read select 0", rd, 16'hA1A0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule